// File: doc/BRIEF.md
# Dual-Rail Tri-State Prefix Adder

This block adds two binary operands and a carry-in and gives the sum and carry-out. Every input and output bit is carried on two wires, a true wire and a false wire. When both wires of a pair are low, the pair carries no data and acts as a spacer. The operand width is a parameter. Each bit position is first turned into a one-hot triple: propagate, generate or kill. A radix-2 prefix tree joins these triples into group triples, one level per power of two. Carry cells then turn each group into a true carry and a false carry. A last row forms the sum rails from the held half-sum and the matching carry.

Each row is a registered pipeline stage. A valid token moves through the rows with the data. A new operand pair can enter on every cycle, and invalid slots leave every rail low. A completion flag rises when every sum pair and the carry-out pair has one active wire. An error flag travels with the result and marks any input pair that had both wires active.

Top module: `tri_cla_adder`

## Requirements
- R1: For a well-formed input, {cout_t, sum_t} equals a + b + cin. The operands are taken from the true rails: bit i of the result is sum_t[i], and the carry-out is the top bit.
- R2: A result leaves the block exactly LAT = $clog2(WIDTH) + 3 rising edges after its input is sampled. For the default width this is 9. Inputs can be accepted on back-to-back cycles, and out_valid repeats the in_valid pattern delayed by LAT.
- R3: While reset is active, and in every slot without a valid token, all sum and carry rails, done and rail_err are low.
- R4: Each bit is encoded as p = a xor b, g = a and b, z = (not a) and (not b), and exactly one of these is active for a well-formed pair. Two groups are joined as pp = p1 & p0, gg = g1 | p1 & g0, zz = z1 | p1 & z0, with the higher group on side 1. The bit-0 carry from the three-input majority must agree with the carry that the tree produces.
- R5: The boundary patterns give correct results with correct carry-out. These are all ones plus carry-in, all ones plus all ones plus carry-in, zero plus carry-in, complementary operands, and alternating 0101/1010 operands.
- R6: If any input pair (a, b or cin) has both wires high in a valid slot, rail_err is high together with that result's out_valid. For every other result rail_err is low.
- R7: done is high with out_valid when every sum pair and the carry-out pair has one active wire. If an operand pair was all-low (null) in a valid slot, done stays low for that result.
- R8: For a well-formed input, sum_f equals ~sum_t and cout_f equals ~cout_t, so exactly one wire of each output pair is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input slot carries an operand pair |
| a_t | input | WIDTH | Operand A true rails |
| a_f | input | WIDTH | Operand A false rails |
| b_t | input | WIDTH | Operand B true rails |
| b_f | input | WIDTH | Operand B false rails |
| cin_t | input | 1 | Carry-in true rail |
| cin_f | input | 1 | Carry-in false rail |
| out_valid | output | 1 | Output slot carries a result |
| sum_t | output | WIDTH | Sum true rails |
| sum_f | output | WIDTH | Sum false rails |
| cout_t | output | 1 | Carry-out true rail |
| cout_f | output | 1 | Carry-out false rail |
| done | output | 1 | All output pairs have resolved |
| rail_err | output | 1 | Result came from an input with a pair driven high on both wires |

## Verification
Every result is due LAT rising edges after its input is sampled. Those edges are one for the encode row, one per tree level, one for the carry row and one for the sum row, which is 9 edges at 64 bits. The bench drives and samples on falling edges. It writes each slot's expected value, fault kind and requirement tag into a ring, and compares the outputs exactly LAT falling edges later. This includes checking that out_valid follows bubbles and back-to-back tokens. Slots with bubbles, double-high pairs and null pairs are compared in the same delayed window, so flags and spacers are checked on the same cycle as a sum would be.

// File: rtl/tri_cla_pkg.sv
package tri_cla_pkg;

   // one-hot bit/group class: propagate, generate, kill
   typedef struct packed {
      logic p;
      logic g;
      logic z;
   } tri_t;

   // join a higher group with the lower group adjacent to it
   function automatic tri_t tri_join(tri_t hi, tri_t lo);
      tri_t r;
      r.p = hi.p & lo.p;
      r.g = hi.g | (hi.p & lo.g);
      r.z = hi.z | (hi.p & lo.z);
      return r;
   endfunction

   // three-input majority, used on either rail set
   function automatic logic maj3(logic x, logic y, logic w);
      return (x & y) | (x & w) | (y & w);
   endfunction

endpackage

// File: rtl/tri_encode.sv
module tri_encode #(
   parameter int WIDTH  = 64,
   parameter int SIDE_W = 2*WIDTH + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WIDTH-1:0]  a_t,
   input  logic [WIDTH-1:0]  a_f,
   input  logic [WIDTH-1:0]  b_t,
   input  logic [WIDTH-1:0]  b_f,
   input  logic              cin_t,
   input  logic              cin_f,
   output logic              v_q,
   output logic [WIDTH-1:0]  p_q,
   output logic [WIDTH-1:0]  g_q,
   output logic [WIDTH-1:0]  z_q,
   output logic [SIDE_W-1:0] side_q
);
   import tri_cla_pkg::*;

   localparam int CIN_T = 2*WIDTH;
   localparam int CIN_F = 2*WIDTH + 1;
   localparam int C1_T  = 2*WIDTH + 2;
   localparam int C1_F  = 2*WIDTH + 3;
   localparam int ERR   = 2*WIDTH + 4;

   logic [WIDTH-1:0]  p_d, g_d, z_d;
   logic [SIDE_W-1:0] side_d;
   logic              err_d;

   // dual-rail xor / and / nor: a null pair yields no active class
   assign p_d = (a_t & b_f) | (a_f & b_t);
   assign g_d = a_t & b_t;
   assign z_d = a_f & b_f;
   assign err_d = (|(a_t & a_f)) | (|(b_t & b_f)) | (cin_t & cin_f);

   always_comb begin
      side_d = '0;
      side_d[WIDTH-1:0]       = p_d;          // half-sum true rail
      side_d[2*WIDTH-1:WIDTH] = g_d | z_d;    // half-sum false rail
      side_d[CIN_T] = cin_t;
      side_d[CIN_F] = cin_f;
      side_d[C1_T]  = maj3(cin_t, a_t[0], b_t[0]);
      side_d[C1_F]  = maj3(cin_f, a_f[0], b_f[0]);
      side_d[ERR]   = err_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         p_q    <= '0;
         g_q    <= '0;
         z_q    <= '0;
         side_q <= '0;
      end else if (in_valid) begin
         v_q    <= 1'b1;
         p_q    <= p_d;
         g_q    <= g_d;
         z_q    <= z_d;
         side_q <= side_d;
      end else begin
         v_q    <= 1'b0;
         p_q    <= '0;
         g_q    <= '0;
         z_q    <= '0;
         side_q <= '0;
      end
   end

   // R4: a well-formed bit never holds two classes at once
   a_r4_onehot_class: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && !side_q[ERR]) |-> (((p_q & g_q) | (p_q & z_q) | (g_q & z_q)) == '0));

   // R3: an empty slot carries spacer rails only
   a_r3_encode_spacer: assert property (@(posedge clk) disable iff (!rst_n)
      !v_q |-> ((p_q | g_q | z_q) == '0));

endmodule

// File: rtl/tri_merge_level.sv
module tri_merge_level #(
   parameter int WIDTH  = 64,
   parameter int DIST   = 1,
   parameter int SIDE_W = 2*WIDTH + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_in,
   input  logic [WIDTH-1:0]  p_in,
   input  logic [WIDTH-1:0]  g_in,
   input  logic [WIDTH-1:0]  z_in,
   input  logic [SIDE_W-1:0] side_in,
   output logic              v_out,
   output logic [WIDTH-1:0]  p_out,
   output logic [WIDTH-1:0]  g_out,
   output logic [WIDTH-1:0]  z_out,
   output logic [SIDE_W-1:0] side_out
);
   import tri_cla_pkg::*;

   localparam int ERR = SIDE_W - 1;

   logic [WIDTH-1:0] p_d, g_d, z_d;

   generate
      if (DIST < 1 || DIST >= WIDTH) begin : g_bad_dist
         $error("tri_merge_level: DIST must lie in 1..WIDTH-1");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i >= DIST) begin : g_join
            tri_t hi, lo, r;
            assign hi = '{p: p_in[i],      g: g_in[i],      z: z_in[i]};
            assign lo = '{p: p_in[i-DIST], g: g_in[i-DIST], z: z_in[i-DIST]};
            assign r  = tri_join(hi, lo);
            assign p_d[i] = r.p;
            assign g_d[i] = r.g;
            assign z_d[i] = r.z;
         end else begin : g_pass
            assign p_d[i] = p_in[i];
            assign g_d[i] = g_in[i];
            assign z_d[i] = z_in[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out    <= 1'b0;
         p_out    <= '0;
         g_out    <= '0;
         z_out    <= '0;
         side_out <= '0;
      end else if (v_in) begin
         v_out    <= 1'b1;
         p_out    <= p_d;
         g_out    <= g_d;
         z_out    <= z_d;
         side_out <= side_in;
      end else begin
         v_out    <= 1'b0;
         p_out    <= '0;
         g_out    <= '0;
         z_out    <= '0;
         side_out <= '0;
      end
   end

   // R2: each level delays the token by exactly one edge
   a_r2_token_step: assert property (@(posedge clk) disable iff (!rst_n)
      v_out == $past(v_in));

   // R4: a group only propagates where its top bit propagated
   a_r4_group_propagate: assert property (@(posedge clk) disable iff (!rst_n)
      (v_out && !side_out[ERR]) |-> ((p_out & ~$past(p_in)) == '0));

endmodule

// File: rtl/tri_carry_sum.sv
module tri_carry_sum #(
   parameter int WIDTH  = 64,
   parameter int SIDE_W = 2*WIDTH + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_in,
   input  logic [WIDTH-1:0]  pp,
   input  logic [WIDTH-1:0]  gg,
   input  logic [WIDTH-1:0]  zz,
   input  logic [SIDE_W-1:0] side_in,
   output logic              out_valid,
   output logic [WIDTH-1:0]  sum_t,
   output logic [WIDTH-1:0]  sum_f,
   output logic              cout_t,
   output logic              cout_f,
   output logic              done,
   output logic              rail_err
);
   localparam int CIN_T = 2*WIDTH;
   localparam int CIN_F = 2*WIDTH + 1;
   localparam int C1_T  = 2*WIDTH + 2;
   localparam int C1_F  = 2*WIDTH + 3;
   localparam int ERR   = 2*WIDTH + 4;

   logic [WIDTH:0]   c_t_d, c_f_d;
   logic [WIDTH:0]   c_t_q, c_f_q;
   logic [WIDTH-1:0] hs_t_q, hs_f_q;
   logic             v_c, err_c;
   logic [WIDTH-1:0] s_t_d, s_f_d;
   logic             done_d;

   wire  cin_t = side_in[CIN_T];
   wire  cin_f = side_in[CIN_F];

   // carry-merge row: group prefix closed with the carry-in rails
   assign c_t_d[0] = cin_t;
   assign c_f_d[0] = cin_f;
   assign c_t_d[1] = side_in[C1_T];
   assign c_f_d[1] = side_in[C1_F];
   generate
      for (genvar i = 1; i < WIDTH; i++) begin : g_carry
         assign c_t_d[i+1] = gg[i] | (pp[i] & cin_t);
         assign c_f_d[i+1] = zz[i] | (pp[i] & cin_f);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_c    <= 1'b0;
         err_c  <= 1'b0;
         c_t_q  <= '0;
         c_f_q  <= '0;
         hs_t_q <= '0;
         hs_f_q <= '0;
      end else if (v_in) begin
         v_c    <= 1'b1;
         err_c  <= side_in[ERR];
         c_t_q  <= c_t_d;
         c_f_q  <= c_f_d;
         hs_t_q <= side_in[WIDTH-1:0];
         hs_f_q <= side_in[2*WIDTH-1:WIDTH];
      end else begin
         v_c    <= 1'b0;
         err_c  <= 1'b0;
         c_t_q  <= '0;
         c_f_q  <= '0;
         hs_t_q <= '0;
         hs_f_q <= '0;
      end
   end

   // dual-rail xor of held half-sum with the incoming carry
   assign s_t_d  = (hs_t_q & c_f_q[WIDTH-1:0]) | (hs_f_q & c_t_q[WIDTH-1:0]);
   assign s_f_d  = (hs_t_q & c_t_q[WIDTH-1:0]) | (hs_f_q & c_f_q[WIDTH-1:0]);
   assign done_d = v_c & (&(s_t_d | s_f_d)) & (c_t_q[WIDTH] | c_f_q[WIDTH]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         sum_t     <= '0;
         sum_f     <= '0;
         cout_t    <= 1'b0;
         cout_f    <= 1'b0;
         done      <= 1'b0;
         rail_err  <= 1'b0;
      end else begin
         out_valid <= v_c;
         sum_t     <= v_c ? s_t_d : '0;
         sum_f     <= v_c ? s_f_d : '0;
         cout_t    <= v_c & c_t_q[WIDTH];
         cout_f    <= v_c & c_f_q[WIDTH];
         done      <= done_d;
         rail_err  <= v_c & err_c;
      end
   end

   // R4: majority carry of bit 0 agrees with the tree's bit-0 group
   a_r4_lsb_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (v_in && !side_in[ERR]) |->
         (side_in[C1_T] == (gg[0] | (pp[0] & cin_t))) &&
         (side_in[C1_F] == (zz[0] | (pp[0] & cin_f))));

   // R8: well-formed results never drive both wires of a pair
   a_r8_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !rail_err) |-> (((sum_t & sum_f) == '0) && !(cout_t && cout_f)));

   // R3: empty output slot is all spacer
   a_r3_output_spacer: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (sum_t == '0 && sum_f == '0 && !cout_t && !cout_f && !done && !rail_err));

   // R7: completion only with a token
   a_r7_done_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> out_valid);

endmodule

// File: rtl/tri_cla_adder.sv
module tri_cla_adder #(
   parameter int WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] a_t,
   input  logic [WIDTH-1:0] a_f,
   input  logic [WIDTH-1:0] b_t,
   input  logic [WIDTH-1:0] b_f,
   input  logic             cin_t,
   input  logic             cin_f,
   output logic             out_valid,
   output logic [WIDTH-1:0] sum_t,
   output logic [WIDTH-1:0] sum_f,
   output logic             cout_t,
   output logic             cout_f,
   output logic             done,
   output logic             rail_err
);
   localparam int LEVELS = $clog2(WIDTH);
   localparam int SIDE_W = 2*WIDTH + 5;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("tri_cla_adder: WIDTH must be at least 2");
      end
   endgenerate

   logic              lv   [0:LEVELS];
   logic [WIDTH-1:0]  lp   [0:LEVELS];
   logic [WIDTH-1:0]  lg   [0:LEVELS];
   logic [WIDTH-1:0]  lz   [0:LEVELS];
   logic [SIDE_W-1:0] lside[0:LEVELS];

   tri_encode #(.WIDTH(WIDTH), .SIDE_W(SIDE_W)) enc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(in_valid),
      .a_t     (a_t),
      .a_f     (a_f),
      .b_t     (b_t),
      .b_f     (b_f),
      .cin_t   (cin_t),
      .cin_f   (cin_f),
      .v_q     (lv[0]),
      .p_q     (lp[0]),
      .g_q     (lg[0]),
      .z_q     (lz[0]),
      .side_q  (lside[0])
   );

   generate
      for (genvar k = 0; k < LEVELS; k++) begin : g_level
         tri_merge_level #(.WIDTH(WIDTH), .DIST(1 << k), .SIDE_W(SIDE_W)) lvl_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .v_in    (lv[k]),
            .p_in    (lp[k]),
            .g_in    (lg[k]),
            .z_in    (lz[k]),
            .side_in (lside[k]),
            .v_out   (lv[k+1]),
            .p_out   (lp[k+1]),
            .g_out   (lg[k+1]),
            .z_out   (lz[k+1]),
            .side_out(lside[k+1])
         );
      end
   endgenerate

   tri_carry_sum #(.WIDTH(WIDTH), .SIDE_W(SIDE_W)) fin_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .v_in     (lv[LEVELS]),
      .pp       (lp[LEVELS]),
      .gg       (lg[LEVELS]),
      .zz       (lz[LEVELS]),
      .side_in  (lside[LEVELS]),
      .out_valid(out_valid),
      .sum_t    (sum_t),
      .sum_f    (sum_f),
      .cout_t   (cout_t),
      .cout_f   (cout_f),
      .done     (done),
      .rail_err (rail_err)
   );

   // R6: an error flag never appears without its token
   a_r6_err_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
      rail_err |-> out_valid);

endmodule

// File: tb/tri_cla_adder_tb.sv
module tri_cla_adder_tb_top;
   localparam int W     = 64;
   localparam int LAT   = $clog2(W) + 3;
   localparam int NSTIM = 300;
   localparam int NCYC  = NSTIM + LAT + 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst_n;
   logic         in_valid;
   logic [W-1:0] a_t, a_f, b_t, b_f;
   logic         cin_t, cin_f;
   logic         out_valid;
   logic [W-1:0] sum_t, sum_f;
   logic         cout_t, cout_f, done, rail_err;

   tri_cla_adder #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
      .cin_t(cin_t), .cin_f(cin_f),
      .out_valid(out_valid), .sum_t(sum_t), .sum_f(sum_f),
      .cout_t(cout_t), .cout_f(cout_f), .done(done), .rail_err(rail_err)
   );

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   // expectation ring, written at drive time, read LAT cycles later
   bit         r_v    [16];
   bit         r_err  [16];
   bit         r_null [16];
   logic [W:0] r_sum  [16];
   string      r_tag  [16];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W:0] act, input logic [W:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // fault: 0 none, 1 both rails of b[fbit], 2 null a[fbit], 3 both cin rails
   task automatic drive(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit cin, input int fault, input int fbit);
      in_valid = v;
      if (!v) begin
         a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
      end else begin
         a_t = a; a_f = ~a; b_t = b; b_f = ~b; cin_t = cin; cin_f = ~cin;
         if (fault == 1) begin b_t[fbit] = 1'b1; b_f[fbit] = 1'b1; end
         if (fault == 2) begin a_t[fbit] = 1'b0; a_f[fbit] = 1'b0; end
         if (fault == 3) begin cin_t = 1'b1; cin_f = 1'b1; end
      end
   endtask

   task automatic compare(input int idx);
      if (!r_v[idx]) begin
         check(out_valid == 1'b0, "R2", "bubble out_valid", (W+1)'(out_valid), '0);
         check(sum_t == '0 && sum_f == '0 && !cout_t && !cout_f && !done && !rail_err,
               "R3", "spacer rails", {cout_t, sum_t} | {cout_f, sum_f}, '0);
      end else begin
         check(out_valid == 1'b1, "R2", "token out_valid", (W+1)'(out_valid), (W+1)'(1));
         if (r_err[idx]) begin
            check(rail_err == 1'b1, "R6", "double-high flag", (W+1)'(rail_err), (W+1)'(1));
         end else if (r_null[idx]) begin
            check(done == 1'b0, "R7", "null pair done", (W+1)'(done), '0);
            check(rail_err == 1'b0, "R6", "null pair flag", (W+1)'(rail_err), '0);
         end else begin
            check({cout_t, sum_t} == r_sum[idx], r_tag[idx], "true rails",
                  {cout_t, sum_t}, r_sum[idx]);
            check({cout_f, sum_f} == ~r_sum[idx], "R8", "false rails",
                  {cout_f, sum_f}, ~r_sum[idx]);
            check(done == 1'b1, "R7", "done", (W+1)'(done), (W+1)'(1));
            check(rail_err == 1'b0, "R6", "clean flag", (W+1)'(rail_err), '0);
         end
      end
   endtask

   initial begin
      logic [W-1:0] a, b;
      bit           cin, v;
      int           fault, fbit, mode, idx;
      string        tag;
      void'($urandom(32'd7351));
      rst_n = 1'b0;
      drive(1'b0, '0, '0, 1'b0, 0, 0);
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         @(negedge clk);
         if (cyc == 2)
            check(!out_valid && sum_t == '0 && sum_f == '0 && !cout_t && !cout_f &&
                  !done && !rail_err, "R3", "reset state",
                  {cout_t, sum_t} | {cout_f, sum_f}, '0);
         if (cyc >= LAT) compare((cyc - LAT) % 16);
         if (cyc == 4) rst_n = 1'b1;
         v = 1'b0; a = '0; b = '0; cin = 1'b0; fault = 0; fbit = 0; tag = "R1";
         if (cyc >= 5 && cyc < NSTIM) begin
            v = 1'b1;
            case (cyc - 5)
               0: begin a = '1; b = '0; cin = 1'b1; tag = "R5"; end
               1: begin a = '1; b = '1; cin = 1'b1; tag = "R5"; end
               2: begin tag = "R5"; end
               3: begin cin = 1'b1; tag = "R5"; end
               4: begin a = {(W/2){2'b01}}; b = {(W/2){2'b10}}; cin = 1'b1; tag = "R5"; end
               5: begin a = {(W/2){2'b10}}; b = {(W/2){2'b10}}; tag = "R5"; end
               6: v = 1'b0;
               7: begin a = 64'h1234; b = 64'h5678; fault = 1; fbit = 17; end
               8: begin a = '1; b = 64'h1; fault = 2; fbit = 40; end
               9: begin a = 64'h99; b = 64'h1; fault = 3; end
               10: begin a = 64'h1; b = '1; tag = "R5"; end
               default: begin
                  mode = $urandom_range(0, 15);
                  a = {$urandom, $urandom};
                  b = {$urandom, $urandom};
                  cin = 1'($urandom);
                  tag = "R4";   // R1 R4: random sums through encode and tree
                  if (mode == 0) v = 1'b0;
                  else if (mode == 1) begin fault = 1; fbit = $urandom_range(0, W-1); end
                  else if (mode == 2) begin fault = 2; fbit = $urandom_range(0, W-1); end
                  else if (mode == 3) begin b = ~a; tag = "R5"; end
               end
            endcase
         end
         idx = cyc % 16;
         r_v[idx]    = v;
         r_err[idx]  = (fault == 1) || (fault == 3);
         r_null[idx] = (fault == 2);
         r_sum[idx]  = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
         r_tag[idx]  = tag;
         drive(v, a, b, cin, fault, fbit);
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL R2 watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule